// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block drives the two-wire station management link between a host and one or more Ethernet PHYs. The host writes a 32-bit command word, and the block shifts it out on MDIO as a management frame, timed by a management clock (MDC) that it divides down from the system clock. Read frames return 16 bits from the PHY. Those bits are merged into the command word in place of its data field, so the host reads the result back from the register it wrote.

A control word sets the divider ratio N. MDC runs at the system clock over 2N, and N equal to zero parks MDC low. A second control bit drops the 32-ones preamble for PHYs that do not need it. A sticky completion flag tells the host when the frame is over. The command register stays live while a frame runs, so a rewrite during a frame changes the bits still to be sent.

Register addresses: 0 is the command/data word, 1 is the control word, 2 is status. Status reads as bit 0 done flag and bit 1 busy. Writing 1 to status bit 0 clears the flag. The command word, numbered from bit 31 down, is: start [31:30] = 01, opcode [29:28] (01 write, 10 read), PHY address [27:23], register address [22:18], turnaround [17:16], data [15:0].

Top module: `mdio_frame_ctrl`

## Requirements
- R1: With the control speed field N (control bits [6:1]) nonzero, MDC is a free-running square wave with a period of 2N system clocks, high for N and low for N.
- R2: With N equal to zero, MDC stays low, and a command write starts no frame (busy stays 0).
- R3: With control bit 7 clear, each frame is preceded by 32 driven ones. With control bit 7 set, the frame begins directly with the start bits.
- R4: All registers reset to zero. The control word reads back only bits [7:1], and every other bit reads zero whatever was written.
- R5: Frame bits leave MSB first, from command bit 31 down to bit 0. MDIO changes only as MDC falls, so it is stable while MDC is high. On write frames the turnaround is driven as 1 then 0, whatever the command word holds there.
- R6: On read frames (opcode 10) the MDIO output enable is deasserted from the first turnaround bit through the last data bit. Only 14 header bits are driven after the preamble.
- R7: After a read frame, the command register returns every bit the host wrote except bits [15:0]. Those hold the 16 bits sampled from MDIO on the rising MDC edges of the data phase, first sample in bit 15.
- R8: The done flag (status bit 0) is set in the cycle busy falls at the end of a frame. It stays set until the host writes 1 to status bit 0.
- R9: Busy (port and status bit 1) rises the cycle after a starting command write and falls as the last data bit's MDC period ends. The output enable is never asserted while busy is low.
- R10: A command write while busy does not restart the frame. Bits sent after the write come from the new word.
- R11: If a done-flag clear and a frame completion happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select (0 command, 1 control, 2 status) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Sticky completion flag |

## Verification
Two functions can land in one cycle: the completion that sets the done flag, and a host write that clears it. The test holds a clear write on the status register for every cycle of a frame, so the clear is certain to coincide with the completion edge. It then expects the flag to be 1 in the cycle busy falls and 0 one cycle later, once the still-pending clear takes effect. A second overlap is a command rewrite landing in the middle of the data phase. It is judged by the exact split between old and new data bits seen on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CMD_W  = 32;
    localparam int DATA_W = 16;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // bit index of the first turnaround bit in the command word
    localparam int TA_HI = 17;
    localparam int TA_LO = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARM,
        SEQ_PRE,
        SEQ_FRAME
    } seq_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             mdc_rise,
    output logic             mdc_fall
);

    typedef struct packed {
        logic [SPD_W-1:0] cnt;
        logic             level;
    } clk_state_t;

    clk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        mdc_rise = 1'b0;
        mdc_fall = 1'b0;
        if (speed == '0) begin
            st_d.cnt   = '0;
            st_d.level = 1'b0;
        end else if (st_q.cnt >= speed - SPD_W'(1)) begin
            // half period complete: toggle
            st_d.cnt   = '0;
            st_d.level = ~st_q.level;
            mdc_rise   = ~st_q.level;
            mdc_fall   = st_q.level;
        end else begin
            st_d.cnt = st_q.cnt + SPD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.level;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [CMD_W-1:0]  host_wdata,
    output logic [CMD_W-1:0]  host_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              cap_we,
    input  logic [3:0]        cap_idx,
    input  logic              cap_bit,
    output logic [CMD_W-1:0]  cmd,
    output logic [SPD_W-1:0]  speed,
    output logic              skip_pre,
    output logic              start,
    output logic              irq
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [SPD_W-1:0] spd;
        logic             skip;
        logic             flag;
    } reg_state_t;

    reg_state_t rg_d, rg_q;

    always_comb begin
        rg_d  = rg_q;
        start = host_wr && (host_addr == ADDR_CMD) && (rg_q.spd != '0) && !busy;

        // read data capture from the sequencer
        if (cap_we) rg_d.cmd[cap_idx] = cap_bit;

        if (host_wr) begin
            case (host_addr)
                ADDR_CMD:  rg_d.cmd = host_wdata;
                ADDR_CTRL: begin
                    rg_d.spd  = host_wdata[SPD_W:1];
                    rg_d.skip = host_wdata[SPD_W+1];
                end
                ADDR_STAT: if (host_wdata[0]) rg_d.flag = 1'b0;
                default: ;
            endcase
        end

        // completion beats a same-cycle clear
        if (done) rg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_CMD:  host_rdata = rg_q.cmd;
            ADDR_CTRL: begin
                host_rdata[SPD_W:1]  = rg_q.spd;
                host_rdata[SPD_W+1]  = rg_q.skip;
            end
            ADDR_STAT: begin
                host_rdata[0] = rg_q.flag;
                host_rdata[1] = busy;
            end
            default: host_rdata = '0;
        endcase
    end

    assign cmd      = rg_q.cmd;
    assign speed    = rg_q.spd;
    assign skip_pre = rg_q.skip;
    assign irq      = rg_q.flag;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mdc_rise,
    input  logic             mdc_fall,
    input  logic             skip_pre,
    input  logic [CMD_W-1:0] cmd,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             busy,
    output logic             done,
    output logic             cap_we,
    output logic [3:0]       cap_idx,
    output logic             cap_bit
);

    localparam int PC_W  = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam int IDX_W = $clog2(CMD_W);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [PC_W-1:0]  pcnt;
        logic             dout;
        logic             den;
    } seq_t;

    seq_t sq_d, sq_q;

    logic             is_rd;
    logic [IDX_W-1:0] nidx;
    logic             nbit;
    logic             nen;

    always_comb begin
        is_rd = (cmd[29:28] == OP_READ);
        nidx  = sq_q.idx - IDX_W'(1);
        // turnaround forced to 1,0 on writes
        if (!is_rd && nidx == IDX_W'(TA_HI))      nbit = 1'b1;
        else if (!is_rd && nidx == IDX_W'(TA_LO)) nbit = 1'b0;
        else                                      nbit = cmd[nidx];
        nen = !(is_rd && nidx <= IDX_W'(TA_HI));
    end

    always_comb begin
        sq_d    = sq_q;
        done    = 1'b0;
        cap_we  = 1'b0;
        cap_idx = sq_q.idx[3:0];
        cap_bit = mdio_i;
        case (sq_q.st)
            SEQ_IDLE: begin
                if (start) sq_d.st = SEQ_ARM;
            end
            SEQ_ARM: begin
                if (mdc_fall) begin
                    sq_d.den = 1'b1;
                    if (skip_pre) begin
                        sq_d.st   = SEQ_FRAME;
                        sq_d.idx  = IDX_W'(CMD_W - 1);
                        sq_d.dout = cmd[CMD_W-1];
                    end else begin
                        sq_d.st   = SEQ_PRE;
                        sq_d.pcnt = '0;
                        sq_d.dout = 1'b1;
                    end
                end
            end
            SEQ_PRE: begin
                if (mdc_fall) begin
                    if (sq_q.pcnt == PC_W'(PRE_LEN - 1)) begin
                        sq_d.st   = SEQ_FRAME;
                        sq_d.idx  = IDX_W'(CMD_W - 1);
                        sq_d.dout = cmd[CMD_W-1];
                    end else begin
                        sq_d.pcnt = sq_q.pcnt + PC_W'(1);
                    end
                end
            end
            SEQ_FRAME: begin
                if (mdc_rise && is_rd && sq_q.idx < IDX_W'(DATA_W)) cap_we = 1'b1;
                if (mdc_fall) begin
                    if (sq_q.idx == '0) begin
                        sq_d.st   = SEQ_IDLE;
                        sq_d.dout = 1'b0;
                        sq_d.den  = 1'b0;
                        done      = 1'b1;
                    end else begin
                        sq_d.idx  = nidx;
                        sq_d.dout = nbit;
                        sq_d.den  = nen;
                    end
                end
            end
            default: sq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SEQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign mdio_o  = sq_q.dout;
    assign mdio_oe = sq_q.den;
    assign busy    = (sq_q.st != SEQ_IDLE);

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        busy,
    output logic        irq
);

    logic [CMD_W-1:0] cmd_w;
    logic [SPD_W-1:0] speed_w;
    logic             skip_w;
    logic             start_w;
    logic             rise_w;
    logic             fall_w;
    logic             done_w;
    logic             cap_we_w;
    logic [3:0]       cap_idx_w;
    logic             cap_bit_w;

    mdio_regs #(.SPD_W(SPD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done_w),
        .cap_we     (cap_we_w),
        .cap_idx    (cap_idx_w),
        .cap_bit    (cap_bit_w),
        .cmd        (cmd_w),
        .speed      (speed_w),
        .skip_pre   (skip_w),
        .start      (start_w),
        .irq        (irq)
    );

    mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed    (speed_w),
        .mdc      (mdc),
        .mdc_rise (rise_w),
        .mdc_fall (fall_w)
    );

    mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .mdc_rise (rise_w),
        .mdc_fall (fall_w),
        .skip_pre (skip_w),
        .cmd      (cmd_w),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .done     (done_w),
        .cap_we   (cap_we_w),
        .cap_idx  (cap_idx_w),
        .cap_bit  (cap_bit_w)
    );

endmodule

// File: rtl/mdio_frame_ctrl_checker.sv
module mdio_frame_ctrl_checker #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             irq,
    input logic             host_wr,
    input logic [1:0]       host_addr,
    input logic             host_clr,
    input logic [SPD_W-1:0] speed
);

    logic clr_req;
    assign clr_req = host_wr && (host_addr == 2'd2) && host_clr;

    // R2: parked divider keeps MDC low
    p_mdc_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == '0) |=> !mdc);

    // R2: no frame may begin with the divider parked
    p_no_start_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == '0 && !busy) |=> !busy);

    // R5: MDIO only moves on the falling MDC edge
    p_mdio_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    // R9: output enable only inside a frame
    p_oe_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R8: flag holds until cleared
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_req) |=> irq);

    // R8: flag is only raised as a frame ends
    p_flag_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_checker #(.SPD_W(SPD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .irq       (irq),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_clr  (host_wdata[0]),
    .speed     (speed_w)
);

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, busy, irq;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    mdio_frame_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .busy(busy), .irq(irq)
    );

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // {speed6, skip1, op2, phy5, reg5, data16, phy_reply16}
    localparam int NV = 6;
    localparam logic [50:0] VEC [NV] = '{
        {6'd1, 1'b0, 2'b01, 5'h01, 5'h02, 16'hA5C3, 16'h0000},
        {6'd2, 1'b1, 2'b10, 5'h1F, 5'h00, 16'h0000, 16'h1234},
        {6'd3, 1'b0, 2'b10, 5'h05, 5'h11, 16'hFFFF, 16'hBEEF},
        {6'd1, 1'b1, 2'b01, 5'h10, 5'h1F, 16'h0001, 16'h0000},
        {6'd5, 1'b1, 2'b10, 5'h03, 5'h04, 16'h5555, 16'h8001},
        {6'd2, 1'b0, 2'b01, 5'h0A, 5'h15, 16'hFFFE, 16'h0000}
    };

    // PHY-side monitor
    logic [63:0] cap = '0;
    int          ccount = 0;
    int          falls = 0;
    int          pre_off = 32;
    logic [15:0] phy_reply = '0;

    always @(posedge mdc) if (mdio_oe) begin
        cap    = {cap[62:0], mdio_o};
        ccount = ccount + 1;
    end

    always @(negedge mdc) begin
        int j;
        falls = falls + 1;
        j = falls - 1 - pre_off;
        if (j >= 16 && j <= 31) mdio_i = phy_reply[31-j];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // align to MDC, then issue the command write
    task automatic launch(input logic [31:0] c, input bit skip);
        @(negedge mdc);
        @(negedge clk);
        falls = 0; ccount = 0; cap = '0;
        pre_off = skip ? 0 : 32;
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = c;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        failures++;
        $display("FAIL watchdog actual=%0d expected=finish", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R4: reset state
        check(mdc == 1'b0 && busy == 1'b0 && irq == 1'b0, "R4 reset outputs", {mdc, busy, irq}, 0);
        rst_n = 1'b1;
        host_read(2'd0, rd); check(rd == 0, "R4 reset cmd", rd, 0);
        host_read(2'd1, rd); check(rd == 0, "R4 reset ctrl", rd, 0);
        host_read(2'd2, rd); check(rd == 0, "R4 reset status", rd, 0);

        // R4: reserved bits read zero
        host_write(2'd1, 32'hFFFF_FFFF);
        host_read(2'd1, rd); check(rd == 32'h0000_00FE, "R4 ctrl mask", rd, 32'hFE);

        // R2: parked divider
        host_write(2'd1, 32'h0);
        host_write(2'd0, {2'b01, 2'b01, 5'h1, 5'h1, 2'b10, 16'h1234});
        begin
            bit bad = 0;
            repeat (60) begin @(negedge clk); if (mdc || busy) bad = 1; end
            check(!bad, "R2 parked mdc and no frame", bad, 0);
        end

        // vector walk
        for (int v = 0; v < NV; v++) begin
            logic [5:0]  spd;
            logic        skip;
            logic [1:0]  op;
            logic [31:0] word;
            logic [31:0] frame;
            int t0, t1;
            {spd, skip, op} = VEC[v][50:42];
            word  = {2'b01, op, VEC[v][41:32], 2'b10, VEC[v][31:16]};
            frame = word;
            phy_reply = VEC[v][15:0];
            host_write(2'd1, {24'd0, skip, spd, 1'b0});
            host_write(2'd2, 32'h1);
            // R1: MDC period
            @(posedge mdc); t0 = cyc;
            @(posedge mdc); t1 = cyc;
            check(t1 - t0 == 2 * spd, "R1 mdc period", t1 - t0, 2 * spd);
            launch(word, skip);
            check(busy == 1'b1, "R9 busy after start", busy, 1);
            wait_idle();
            check(irq == 1'b1, "R8 flag at frame end", irq, 1);
            if (op == 2'b01) begin
                check(ccount == (skip ? 32 : 64), "R3 driven bit count", ccount, skip ? 32 : 64);
                check(cap[31:0] == frame, "R5 write frame bits", cap[31:0], frame);
                if (!skip) check(cap[63:32] == 32'hFFFF_FFFF, "R3 preamble ones", cap[63:32], 32'hFFFF_FFFF);
            end else begin
                check(ccount == (skip ? 14 : 46), "R6 read release", ccount, skip ? 14 : 46);
                check(cap[13:0] == word[31:18], "R5 read header bits", cap[13:0], word[31:18]);
                host_read(2'd0, rd);
                check(rd == {word[31:16], phy_reply}, "R7 read merge", rd, {word[31:16], phy_reply});
            end
            host_read(2'd2, rd);
            check(rd[1:0] == 2'b01, "R9 status idle flag set", rd[1:0], 2'b01);
            host_write(2'd2, 32'h1);
            host_read(2'd2, rd);
            check(rd[0] == 1'b0, "R8 write one clears", rd[0], 0);
        end

        // R10: rewrite in the data phase
        host_write(2'd1, {24'd0, 1'b1, 6'd1, 1'b0});
        launch({2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'h0000}, 1'b1);
        wait (falls == 20);
        host_write(2'd0, {2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'hFFFF});
        wait_idle();
        check(ccount == 32, "R10 no restart", ccount, 32);
        check(cap[15:0] == 16'h0FFF, "R10 mixed data bits", cap[15:0], 16'h0FFF);
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R10 stays idle", busy, 0);
        host_write(2'd2, 32'h1);

        // R11: clear held through completion
        launch({2'b01, 2'b01, 5'h04, 5'h05, 2'b10, 16'h00FF}, 1'b1);
        host_wr = 1'b1; host_addr = 2'd2; host_wdata = 32'h1;
        wait_idle();
        check(irq == 1'b1, "R11 set wins over clear", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R11 later clear applies", irq, 0);
        host_wr = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule